// File: doc/BRIEF.md
# SONET Overhead Serial Output Port

This block turns the transport overhead of an STS-12 frame into a bit-serial stream on a dedicated overhead clock. Each frame row carries 36 overhead bytes. The block fetches them one at a time through a byte request and valid handshake. It shifts them out most significant bit first and marks each row with a qualifier and a one-cycle row pulse. The byte source is the receive datapath.

The block rewrites a few bits on the way out. The most significant bit of the first byte of each frame carries even parity over the previous frame. The K1/K2 region can be zeroed under a control input. When line AIS is active, every bit goes high, including the parity bit. AIS can come from an out-of-frame indication or from a force input.

Rows are started by the receive framer, one `row_go` pulse per row. `frame_go` is raised together with the `row_go` of the first row of each frame. Between rows the serial port is idle while the payload part of the row passes.

Top module: `oh_serial_tx`

## Requirements
- R1: `ser_en` goes high on the cycle after a row start is sampled. It stays high for exactly 288 consecutive cycles (36 bytes × 8 bits) and is low at all other times unless a new row starts.
- R2: The serial bits of a row are the 36 requested bytes in request order, each sent bit 7 first and bit 0 last, one bit per cycle with no gaps.
- R3: `row_fp` is high for exactly one cycle per row, in the same cycle as the first qualified bit of that row.
- R4: Bit 7 of byte 0 of row 0 is replaced by even parity. Its value is the XOR of every bit sent in the previous frame except that frame's own parity position. The first frame after reset carries 0.
- R5: While `ais_force` or `oof` is high when a byte is loaded, that byte is sent as all ones. This includes the parity position.
- R6: With `kbyte_zero` high, bytes 12 through 35 of row 4 are sent as zero. These bytes hold the K1 and K2 copies in STS-12 order. With `kbyte_zero` low, they pass through.
- R7: `byte_req` is high in each cycle whose closing edge captures a byte. `byte_in` is taken at that edge when `byte_valid` is high; otherwise the byte is 0x00.
- R8: Synchronous reset clears parity, row and byte state and drives `ser_en` and `row_fp` low. Row starts are then ignored, with no request and no output, until a frame start arrives.
- R9: A frame start (`row_go` and `frame_go` together) sets the row index to 0. Each later row start increments it, saturating at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Overhead clock |
| rst | input | 1 | Synchronous reset, active high |
| row_go | input | 1 | Pulse: start sending a row |
| frame_go | input | 1 | With row_go: this row is row 0 of a frame |
| ais_force | input | 1 | Force line AIS |
| oof | input | 1 | Out-of-frame condition, also gives line AIS |
| kbyte_zero | input | 1 | Zero the K1/K2 bytes of row 4 |
| byte_in | input | 8 | Overhead byte from the source |
| byte_valid | input | 1 | byte_in is valid |
| byte_req | output | 1 | Byte is captured at the coming edge |
| ser_out | output | 1 | Serial overhead data |
| ser_en | output | 1 | Serial data qualifier |
| row_fp | output | 1 | One-cycle row pulse |

## Verification
`byte_req` is combinational and is due in the same cycle as the row start or the last bit of the previous byte. The bench reads it half a cycle after driving that stimulus. A row start driven before an edge yields `ser_en`, `row_fp` and the first data bit one register later, so the bench drives at the falling edge and samples the first bit at the next falling edge. It then takes one sample per falling edge for 288 cycles and checks that the qualifier is low at the 289th. Parity is predicted from the bench's own model of the previous frame's transmitted bits and is checked at the first bit of the next frame.

// File: rtl/oh_serial_tx.sv
module oh_serial_tx #(
  parameter int BYTES_PER_ROW = 36,
  parameter int K_ROW         = 4,
  parameter int K_FIRST       = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       row_go,
  input  logic       frame_go,
  input  logic       ais_force,
  input  logic       oof,
  input  logic       kbyte_zero,
  input  logic [7:0] byte_in,
  input  logic       byte_valid,
  output logic       byte_req,
  output logic       ser_out,
  output logic       ser_en,
  output logic       row_fp
);
  localparam int BW = $clog2(BYTES_PER_ROW);
  localparam logic [BW-1:0] LAST = BW'(BYTES_PER_ROW - 1);

  logic          synced, active, fp, par_acc;
  logic [7:0]    sh, d;
  logic [2:0]    bitc;
  logic [BW-1:0] bytec, load_idx;
  logic [3:0]    rowc, load_row;

  wire start     = row_go & (synced | frame_go);
  wire new_frame = start & frame_go;
  wire next_byte = active & (bitc == 3'd7) & (bytec != LAST);

  assign byte_req = start | next_byte;
  assign load_idx = start ? '0 : bytec + 1'b1;
  assign load_row = new_frame ? 4'd0 :
                    start     ? ((rowc == 4'd15) ? rowc : rowc + 4'd1) : rowc;

  wire first = (load_row == 4'd0) && (load_idx == '0);
  wire kz    = kbyte_zero && (load_row == 4'(K_ROW)) && (load_idx >= BW'(K_FIRST));
  wire ais   = ais_force | oof;

  always_comb begin
    d = (byte_valid && !kz) ? byte_in : 8'h00;
    if (first) d[7] = par_acc;
    if (ais)   d = 8'hFF;
  end

  wire par_bits = first ? ^d[6:0] : ^d;

  assign ser_out = sh[7];
  assign ser_en  = active;
  assign row_fp  = fp;

  always_ff @(posedge clk) begin
    if (rst) begin
      synced  <= 1'b0;
      active  <= 1'b0;
      fp      <= 1'b0;
      par_acc <= 1'b0;
      sh      <= '0;
      bitc    <= '0;
      bytec   <= '0;
      rowc    <= '0;
    end else begin
      fp <= start;
      if (new_frame) synced <= 1'b1;
      if (byte_req) begin
        sh      <= d;
        bitc    <= '0;
        bytec   <= load_idx;
        rowc    <= load_row;
        active  <= 1'b1;
        par_acc <= new_frame ? par_bits : (par_acc ^ par_bits);
      end else if (active) begin
        sh   <= {sh[6:0], 1'b0};
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/oh_serial_tx_chk.sv
module oh_serial_tx_chk #(
  parameter int BYTES_PER_ROW = 36
) (
  input logic clk,
  input logic rst,
  input logic row_go,
  input logic frame_go,
  input logic ais_force,
  input logic oof,
  input logic byte_req,
  input logic ser_out,
  input logic ser_en,
  input logic row_fp
);
  localparam int ROW_BITS = BYTES_PER_ROW * 8;
  localparam int CW = $clog2(ROW_BITS) + 1;

  logic          seen, ais_l;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 1'b0;
      ais_l <= 1'b0;
      cnt   <= '0;
    end else begin
      if (row_go && frame_go) seen <= 1'b1;
      if (byte_req) ais_l <= ais_force | oof;
      cnt <= row_fp ? CW'(1) : (ser_en ? cnt + 1'b1 : '0);
    end
  end

  AST_FP_HAS_EN:  assert property (@(posedge clk) disable iff (rst) row_fp |-> ser_en);                          // R3
  AST_FP_SINGLE:  assert property (@(posedge clk) disable iff (rst) row_fp && !row_go |=> !row_fp);             // R3
  AST_ROW_LEN:    assert property (@(posedge clk) disable iff (rst) ser_en && !row_fp |-> cnt < CW'(ROW_BITS)); // R1
  AST_NO_EN_IDLE: assert property (@(posedge clk) disable iff (rst) !seen |-> !ser_en);                          // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst) !seen && !(row_go && frame_go) |-> !byte_req); // R8
  AST_AIS_ONES:   assert property (@(posedge clk) disable iff (rst) ser_en && ais_l |-> ser_out);               // R5
endmodule

bind oh_serial_tx oh_serial_tx_chk #(.BYTES_PER_ROW(BYTES_PER_ROW)) u_chk (
  .clk(clk), .rst(rst), .row_go(row_go), .frame_go(frame_go),
  .ais_force(ais_force), .oof(oof), .byte_req(byte_req),
  .ser_out(ser_out), .ser_en(ser_en), .row_fp(row_fp)
);

// File: tb/oh_serial_tx_tb.sv
module oh_serial_tx_tb;
  localparam int NB = 36;
  localparam int ROW_BITS = NB * 8;
  // seed[11:4] kz[3] force[2] oof[1] valid[0]
  localparam logic [11:0] VEC [0:6] = '{
    {8'd1, 4'b0001}, {8'd2, 4'b1001}, {8'd3, 4'b0101}, {8'd4, 4'b0001},
    {8'd5, 4'b0011}, {8'd6, 4'b1000}, {8'd7, 4'b0001}
  };

  logic clk = 0, rst = 1;
  logic row_go = 0, frame_go = 0, ais_force = 0, oof = 0, kbyte_zero = 0, byte_valid = 1;
  logic [7:0] byte_in;
  logic byte_req, ser_out, ser_en, row_fp;
  logic [7:0] cfg_seed = 0;
  int k = 0;
  int checks = 0, failures = 0;
  bit mpar = 0, fpar = 0, last_first = 0, done = 0;

  always #10 clk = ~clk;

  oh_serial_tx u_dut (.*);

  function automatic logic [7:0] pat(input logic [7:0] s, input int n);
    return 8'(s * 29 + n * 7 + (n >> 2) * 3) ^ 8'(n >> 5);
  endfunction

  assign byte_in = pat(cfg_seed, (frame_go && row_go) ? 0 : k);
  always @(posedge clk) if (byte_req) k <= (frame_go && row_go) ? 1 : k + 1;

  task automatic chk(input bit ok, input string tag, input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_row(input int r, input bit fr);
    logic [287:0] cap, expv;
    bit fpok = 1, enok = 1;
    bit ais = ais_force | oof;
    string tag;
    @(negedge clk); row_go = 1; frame_go = fr;
    @(negedge clk); row_go = 0; frame_go = 0;
    for (int i = 0; i < ROW_BITS; i++) begin
      cap[287-i] = ser_out;
      if (row_fp !== (i == 0)) fpok = 0;
      if (ser_en !== 1'b1) enok = 0;
      @(negedge clk);
    end
    if (ser_en !== 1'b0) enok = 0;
    for (int b = 0; b < NB; b++) begin
      logic [7:0] e;
      e = byte_valid ? pat(cfg_seed, r * NB + b) : 8'h00;
      if (kbyte_zero && r == 4 && b >= 12) e = 8'h00;
      if (r == 0 && b == 0) e[7] = mpar;
      if (ais) e = 8'hFF;
      fpar = fpar ^ ((r == 0 && b == 0) ? ^e[6:0] : ^e);
      expv[287-8*b -: 8] = e;
    end
    tag = ais ? "R5 AIS row" : (kbyte_zero && r == 4) ? "R6/R9 K zero row" :
          !byte_valid ? "R7 invalid bytes" : "R2 row data";
    chk(cap === expv, tag, cap, expv);
    chk(fpok, "R3 row pulse", 288'(row_fp), 288'(1));
    chk(enok, "R1 enable window", 288'(ser_en), 288'(0));
    if (r == 0) begin
      last_first = cap[287];
      chk(cap[287] === (ais ? 1'b1 : mpar), ais ? "R5 parity forced" : "R4 parity bit",
          288'(cap[287]), 288'(ais ? 1'b1 : mpar));
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic [11:0] v);
    @(negedge clk);
    cfg_seed = v[11:4]; kbyte_zero = v[3]; ais_force = v[2]; oof = v[1]; byte_valid = v[0];
    fpar = 0;
    for (int r = 0; r < 9; r++) run_row(r, r == 0);
    mpar = fpar;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; mpar = 0;
  endtask

  initial begin
    do_reset();
    chk(ser_en === 0 && row_fp === 0 && byte_req === 0, "R8 reset state",
        288'({ser_en, row_fp, byte_req}), 288'(0));
    for (int i = 0; i < 7; i++) run_frame(VEC[i]);

    run_frame({8'd9, 4'b0101});
    do_reset();
    @(negedge clk); row_go = 1;
    #1 chk(byte_req === 0, "R8 row start ignored before sync (req)", 288'(byte_req), 288'(0));
    @(negedge clk); row_go = 0;
    begin
      bit quiet = 1;
      repeat (10) begin
        if (ser_en !== 0 || row_fp !== 0) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R8 row start ignored before sync (output)", 288'(quiet), 288'(1));
    end
    run_frame({8'd11, 4'b0001});
    chk(last_first === 1'b0, "R8 parity cleared by reset", 288'(last_first), 288'(0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule